// File: doc/BRIEF.md
# Streaming Configuration Image Header Parser

This block watches the opening bytes of a configuration image as they arrive, one byte on each cycle where `in_valid` is high. In a single pass, without buffering the header, it pulls out the byte offset at which the configuration payload begins. It also works out how many payload bytes follow. It reports success or a parse error. Forwarding the payload to its destination is left to surrounding logic, which uses `pay_start` and `pay_bytes` once `done` rises.

The image gives its header length in one byte. The byte just before the end of that header gives the number of table records. The records follow the header, nine bytes each: a block identifier, then a 32-bit little-endian start offset, then padding. Two identifiers matter. One points at the payload and the other points at a list of component sizes. The number of components is a 16-bit little-endian count at a fixed image position. The size list holds one 22-bit field per component, packed back to back with no padding and read least-significant bit first. Each size counts 16-byte frames.

A new image is parsed after a reset.

Top module: `bitstream_header_parser`

## Requirements
- R1: After reset `done`, `err`, `pay_start` and `pay_bytes` are all zero.
- R2: The header length H is the byte at image offset 24, and the record count is the byte at offset H-1. A header length below 26 sets `err`.
- R3: Table records start at offset H and are 9 bytes long. Byte 0 is the identifier and bytes 1..4 are a little-endian start offset. Identifier 8 gives the payload start, driven on `pay_start`. Identifier 5 gives the size-list start.
- R4: Once both starts hold nonzero values, the remaining records are ignored and neither start changes.
- R5: If the record count is zero, or either start is still zero after the last record, `err` is set.
- R6: The component count is the little-endian 16-bit value at offsets 55 and 56. Component i is the 22-bit field at bit i*22 of the size list, with bit j of the field at bit (i*22+j) mod 8 of byte (i*22+j)/8. `pay_bytes` equals 16 times the sum of the fields.
- R7: With a component count of zero, `done` rises with `pay_bytes` equal to zero once both starts are found.
- R8: Bytes at or past the payload start are never used as size data. If such a byte arrives before every component has been summed, `err` is set.
- R9: A size-list start below 57, or not past the position of the byte that completes its record offset, sets `err`.
- R10: `done` and `err` are never high together and each stays high until reset. Once either is high, further bytes change no output.
- R11: Cycles with `in_valid` low do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new image |
| in_valid | input | 1 | `in_byte` carries the next image byte |
| in_byte | input | 8 | Image byte |
| pay_start | output | 32 | Payload start offset from the table |
| pay_bytes | output | 42 | Payload size in bytes |
| done | output | 1 | Header parsed successfully |
| err | output | 1 | Header could not be parsed |

## Verification
The bench builds the block with its default parameters: 22-bit size fields, 16-byte frames, 9-byte records and 32-bit offsets. With up to six components, the size fields begin at every bit phase a 22-bit field can take within a byte (0, 6, 4 and 2). Fields are driven at all-ones and at single-bit values, so the carry of the accumulated sum and the bit reassembly across byte boundaries both come into play. A header length moved away from its usual value, a duplicate payload record, and idle gaps in the stream check that positions are derived from the data and from valid bytes only.

// File: rtl/hdrp_pkg.sv
package hdrp_pkg;
   // Fixed geometry of the byte stream
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/hdrp_rec_scan.sv
module hdrp_rec_scan
   import hdrp_pkg::*;
#(
   parameter int unsigned OFF_W     = 32,
   parameter int unsigned REC_BYTES = 9,
   parameter int unsigned ID_BS     = 8,
   parameter int unsigned ID_CS     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  byte_t            din,
   output logic             rec_end,
   output logic             cs_hit,
   output logic [OFF_W-1:0] cand_off,
   output logic [OFF_W-1:0] bs_off,
   output logic [OFF_W-1:0] cs_off
);
   localparam int unsigned OB    = OFF_W / 8;
   localparam int unsigned IDX_W = $clog2(REC_BYTES);
   localparam int unsigned AW    = OFF_W - 8;

   logic [IDX_W-1:0] idx;
   byte_t            blk_id;
   logic [AW-1:0]    asm_q;
   logic             both;
   logic             at_last;

   assign both     = (bs_off != '0) && (cs_off != '0);
   assign at_last  = take && (idx == IDX_W'(OB));
   assign cand_off = {din, asm_q};
   assign cs_hit   = at_last && !both && (blk_id == 8'(ID_CS));
   assign rec_end  = take && (idx == IDX_W'(REC_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= '0;
         blk_id <= '0;
         asm_q  <= '0;
         bs_off <= '0;
         cs_off <= '0;
      end else if (take) begin
         idx <= rec_end ? '0 : idx + 1'b1;
         if (idx == '0) blk_id <= din;
         if (idx >= IDX_W'(1) && idx < IDX_W'(OB)) asm_q <= {din, asm_q[AW-1:8]};
         if (at_last && !both) begin
            if (blk_id == 8'(ID_BS)) bs_off <= cand_off;
            if (cs_hit)              cs_off <= cand_off;
         end
      end
   end

   // R3
   rec_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx < IDX_W'(REC_BYTES));
   // R4
   start_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      both |=> ($stable(bs_off) && $stable(cs_off)));
endmodule

// File: rtl/hdrp_size_acc.sv
module hdrp_size_acc
   import hdrp_pkg::*;
#(
   parameter int unsigned SIZE_W = 22,
   parameter int unsigned SUM_W  = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  byte_t            din,
   output logic             ext,
   output logic [SUM_W-1:0] sum
);
   localparam int unsigned BUF_W = SIZE_W + 8;
   localparam int unsigned NB_W  = $clog2(BUF_W);

   logic [BUF_W-1:0] bitbuf, merged;
   logic [NB_W-1:0]  nbits, nfill;

   assign merged = bitbuf | (BUF_W'(din) << nbits);
   assign nfill  = nbits + NB_W'(8);
   assign ext    = take && (nfill >= NB_W'(SIZE_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bitbuf <= '0;
         nbits  <= '0;
         sum    <= '0;
      end else if (take) begin
         if (ext) begin
            sum    <= sum + SUM_W'(merged[SIZE_W-1:0]);
            bitbuf <= merged >> SIZE_W;
            nbits  <= nfill - NB_W'(SIZE_W);
         end else begin
            bitbuf <= merged;
            nbits  <= nfill;
         end
      end
   end

   // R6
   fill_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nbits < NB_W'(SIZE_W));
   // R6
   sum_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(sum));
endmodule

// File: rtl/bitstream_header_parser.sv
module bitstream_header_parser
   import hdrp_pkg::*;
#(
   parameter int unsigned OFF_W       = 32,
   parameter int unsigned SIZE_W      = 22,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned FRAME_SHIFT = 4,
   parameter int unsigned HLEN_POS    = 24,
   parameter int unsigned CNT_POS     = 55,
   parameter int unsigned REC_BYTES   = 9,
   parameter int unsigned ID_BS       = 8,
   parameter int unsigned ID_CS       = 5,
   parameter int unsigned MIN_HLEN    = 26
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   input  logic [7:0]                          in_byte,
   output logic [OFF_W-1:0]                    pay_start,
   output logic [SIZE_W+CNT_W+FRAME_SHIFT-1:0] pay_bytes,
   output logic                                done,
   output logic                                err
);
   localparam int unsigned SUM_W = SIZE_W + CNT_W;
   localparam int unsigned DSZ_W = SUM_W + FRAME_SHIFT;

   if (OFF_W < 24 || (OFF_W % 8) != 0) begin : g_bad_off
      $error("OFF_W must be a byte multiple of at least 24");
   end
   if (CNT_W != 16) begin : g_bad_cnt
      $error("CNT_W must be 16");
   end
   if (SIZE_W < 8) begin : g_bad_size
      $error("SIZE_W must be at least 8");
   end
   if (REC_BYTES < OFF_W / 8 + 1) begin : g_bad_rec
      $error("REC_BYTES too small for the offset");
   end

   logic [OFF_W-1:0] pos;
   byte_t            hlen, rec_left, cnt_lo;
   logic             hlen_ok, tbl_act, tbl_end, cnt_known;
   logic [CNT_W-1:0] comps_left;
   logic             done_r, err_r, stop, acc;
   logic             at_hlen, at_nrec, tbl_take, size_take;
   logic             rec_end, cs_hit, ext;
   logic [OFF_W-1:0] cand_off, bs_off, cs_off;
   logic             bs_found, cs_found;
   logic [SUM_W-1:0] sum;
   logic             err_set, done_set;

   assign stop     = done_r || err_r;
   assign acc      = in_valid && !stop;
   assign at_hlen  = acc && (pos == OFF_W'(HLEN_POS));
   assign at_nrec  = acc && hlen_ok && (pos == {{(OFF_W-8){1'b0}}, hlen} - OFF_W'(1));
   assign tbl_take = acc && tbl_act;
   assign bs_found = (bs_off != '0);
   assign cs_found = (cs_off != '0);
   assign size_take = acc && cnt_known && cs_found && (pos >= cs_off)
                      && (comps_left != '0) && !(bs_found && pos >= bs_off);

   hdrp_rec_scan #(
      .OFF_W(OFF_W), .REC_BYTES(REC_BYTES), .ID_BS(ID_BS), .ID_CS(ID_CS)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .take(tbl_take), .din(in_byte),
      .rec_end(rec_end), .cs_hit(cs_hit), .cand_off(cand_off),
      .bs_off(bs_off), .cs_off(cs_off)
   );

   hdrp_size_acc #(.SIZE_W(SIZE_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .take(size_take), .din(in_byte),
      .ext(ext), .sum(sum)
   );

   always_comb begin
      err_set = 1'b0;
      if (at_hlen && in_byte < 8'(MIN_HLEN)) err_set = 1'b1;
      if (at_nrec && in_byte == '0) err_set = 1'b1;
      if (cs_hit && (cand_off <= pos || cand_off < OFF_W'(CNT_POS + 2))) err_set = 1'b1;
      if (tbl_end && !(bs_found && cs_found)) err_set = 1'b1;
      if (acc && bs_found && pos >= bs_off && !(cnt_known && comps_left == '0))
         err_set = 1'b1;
      if (stop) err_set = 1'b0;
      done_set = !stop && !err_set && bs_found && cs_found
                 && cnt_known && (comps_left == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos        <= '0;
         hlen       <= '0;
         hlen_ok    <= 1'b0;
         rec_left   <= '0;
         tbl_act    <= 1'b0;
         tbl_end    <= 1'b0;
         cnt_lo     <= '0;
         cnt_known  <= 1'b0;
         comps_left <= '0;
         done_r     <= 1'b0;
         err_r      <= 1'b0;
      end else begin
         tbl_end <= 1'b0;
         if (acc) pos <= pos + 1'b1;
         if (at_hlen) begin
            hlen    <= in_byte;
            hlen_ok <= !(in_byte < 8'(MIN_HLEN));
         end
         if (at_nrec) begin
            rec_left <= in_byte;
            tbl_act  <= (in_byte != '0);
         end
         if (rec_end) begin
            rec_left <= rec_left - 1'b1;
            if (rec_left == 8'd1) begin
               tbl_act <= 1'b0;
               tbl_end <= 1'b1;
            end
         end
         if (acc && pos == OFF_W'(CNT_POS)) cnt_lo <= in_byte;
         if (acc && pos == OFF_W'(CNT_POS + 1)) begin
            comps_left <= {in_byte, cnt_lo};
            cnt_known  <= 1'b1;
         end else if (ext) begin
            comps_left <= comps_left - 1'b1;
         end
         if (err_set)  err_r  <= 1'b1;
         if (done_set) done_r <= 1'b1;
      end
   end

   if (FRAME_SHIFT == 0) begin : g_unit
      assign pay_bytes = sum;
   end else begin : g_frames
      assign pay_bytes = {sum, {FRAME_SHIFT{1'b0}}};
   end

   assign pay_start = bs_off;
   assign done      = done_r;
   assign err       = err_r;

   // R10
   no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R10
   out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> ($stable(pay_start) && $stable(pay_bytes)));
   // R5
   done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pay_start != '0));
   // R6
   comp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_known && $past(cnt_known)) |->
      (comps_left == $past(comps_left) || comps_left == $past(comps_left) - 1'b1));
   // R11
   pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(pos));
endmodule

// File: tb/tb_bitstream_header_parser.sv
`timescale 1ns/1ps
module tb_bitstream_header_parser;
   typedef struct packed {
      logic [15:0]      cnt;
      logic [5:0][21:0] sz;
      logic             gap;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [0:NV-1] = '{
      '{cnt:16'd1, sz:'{22'd0, 22'd0, 22'd0, 22'd0, 22'd0, 22'h000001}, gap:1'b0},
      '{cnt:16'd2, sz:'{22'd0, 22'd0, 22'd0, 22'd0, 22'h3FFFFF, 22'h3FFFFF}, gap:1'b1},
      '{cnt:16'd3, sz:'{22'd0, 22'd0, 22'd0, 22'h155555, 22'h2AAAAA, 22'h012345}, gap:1'b0},
      '{cnt:16'd6, sz:'{22'h3FFFFF, 22'd5, 22'd4, 22'd3, 22'd2, 22'd1}, gap:1'b1},
      '{cnt:16'd4, sz:'{22'd0, 22'd0, 22'h1F0F0F, 22'h000100, 22'h300001, 22'h0ABCDE}, gap:1'b0},
      '{cnt:16'd0, sz:'{22'd0, 22'd0, 22'd0, 22'd0, 22'd0, 22'd0}, gap:1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [31:0] pay_start;
   logic [41:0] pay_bytes;
   logic        done, err;

   logic [7:0] img [0:255];
   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   bitstream_header_parser dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .pay_start(pay_start), .pay_bytes(pay_bytes), .done(done), .err(err)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic longint exp_bytes(input vec_t v);
      longint s = 0;
      for (int i = 0; i < 6; i++) if (i < int'(v.cnt)) s += longint'(v.sz[i]);
      return s * 16;
   endfunction

   // Standard layout: records r0 id3, r1 cs_id/cs_off, r2 id8/bs_off, r3 id8/200
   task automatic build(input int hl, input int nrec, input int cs_id,
                        input int cs_off, input int bs_off, input vec_t v);
      for (int i = 0; i < 256; i++) img[i] = 8'h5A ^ 8'(i);
      img[24] = 8'(hl);
      img[hl-1] = 8'(nrec);
      for (int r = 0; r < 4; r++) begin
         int id, off;
         case (r)
            0: begin id = 3; off = 32'h11223344; end
            1: begin id = cs_id; off = cs_off; end
            2: begin id = 8; off = bs_off; end
            default: begin id = 8; off = 200; end
         endcase
         if (r < nrec) begin
            img[hl + 9*r] = 8'(id);
            for (int b = 0; b < 4; b++) img[hl + 9*r + 1 + b] = 8'(off >> (8*b));
         end
      end
      img[55] = v.cnt[7:0];
      img[56] = v.cnt[15:8];
      if (cs_off >= 57 && cs_off < 230) begin
         for (int k = 0; k < 17; k++) img[cs_off + k] = 8'h00;
         for (int i = 0; i < 6; i++)
            if (i < int'(v.cnt))
               for (int b = 0; b < 22; b++)
                  if (v.sz[i][b]) img[cs_off + (i*22+b)/8] |= 8'(1 << ((i*22+b)%8));
      end
   endtask

   task automatic feed(input int n, input logic gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte = img[i];
         if (gap && (i % 3) == 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte = 8'hFF;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      vec_t one;
      longint keep;
      one = VECS[0];

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk("R1", "done", done, 0);
      chk("R1", "err", err, 0);
      chk("R1", "pay_start", pay_start, 0);
      chk("R1", "pay_bytes", pay_bytes, 0);

      // R6 R7 R11 R3 R4: vector table
      for (int n = 0; n < NV; n++) begin
         do_reset();
         build(60, 4, 5, 100, 140, VECS[n]);
         feed(170, VECS[n].gap);
         chk("R6", "done", done, 1);
         chk("R10", "err", err, 0);
         chk("R6", "pay_bytes", pay_bytes, exp_bytes(VECS[n]));
         chk("R4", "pay_start", pay_start, 140);
      end

      // R10: bytes after done change nothing
      keep = longint'(pay_bytes);
      for (int i = 0; i < 256; i++) img[i] = 8'hFF;
      feed(40, 1'b0);
      chk("R10", "pay_bytes after done", pay_bytes, keep);
      chk("R10", "pay_start after done", pay_start, 140);
      chk("R10", "done after done", done, 1);

      // R2: header length taken from offset 24
      do_reset();
      build(70, 4, 5, 110, 150, VECS[2]);
      feed(170, 1'b0);
      chk("R2", "done moved header", done, 1);
      chk("R2", "pay_start moved header", pay_start, 150);
      chk("R2", "pay_bytes moved header", pay_bytes, exp_bytes(VECS[2]));

      // R2: header length too small
      do_reset();
      build(60, 4, 5, 100, 140, one);
      img[24] = 8'd20;
      feed(170, 1'b0);
      chk("R2", "err short header", err, 1);
      chk("R10", "done short header", done, 0);

      // R10: bytes after err change nothing
      keep = longint'(pay_start);
      build(60, 4, 5, 100, 140, one);
      feed(170, 1'b0);
      chk("R10", "err held", err, 1);
      chk("R10", "pay_start after err", pay_start, keep);

      // R5: zero records
      do_reset();
      build(60, 0, 5, 100, 140, one);
      feed(170, 1'b0);
      chk("R5", "err no records", err, 1);

      // R5: size list record missing
      do_reset();
      build(60, 4, 6, 100, 140, one);
      feed(170, 1'b0);
      chk("R5", "err missing list", err, 1);
      chk("R5", "done missing list", done, 0);

      // R9: size-list start below 57
      do_reset();
      build(60, 4, 5, 50, 140, one);
      feed(170, 1'b0);
      chk("R9", "err list before count", err, 1);

      // R9: size-list start not past its own record
      do_reset();
      build(60, 4, 5, 70, 140, one);
      feed(170, 1'b0);
      chk("R9", "err list inside table", err, 1);

      // R8: payload start reached before sizes complete
      do_reset();
      build(60, 4, 5, 100, 105, VECS[3]);
      feed(170, 1'b0);
      chk("R8", "err early payload", err, 1);
      chk("R8", "done early payload", done, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule